// File: doc/BRIEF.md
# Maskable Keypad Interrupt Controller

This block keeps a record of which of sixteen keys are held down and drives an active-low keypad interrupt pin from that record. Key press and release events arrive as per-key strobes. A host reaches four 16-bit registers over a simple single-cycle register bus: a read-only key-data view, a control/status register with a scan flag and a stored debounce field, a mode register, and a key mask.

A press raises the interrupt when at least one unmasked key is down and no interrupt is pending. A two-bit mode chooses how a pending interrupt goes away. It can clear by itself once no unmasked key remains held, or when the host reads the key data. Writing the scan flag as 1 always clears it. Debounce timing and matrix scanning are not part of this block; the debounce field is only stored.

Top module: `kp_irq_ctrl`

## Requirements
- R1: A valid event on key k sets bit k of the down vector on a press and clears it on a release. A read at address 0 returns the down vector, key k at bit k. Writes to address 0 are ignored.
- R2: On a press event, if some unmasked key is down and no interrupt is pending, the interrupt latches and `irq_no` goes low one cycle after the event. A pressed key whose mask bit is 1 does not count as unmasked.
- R3: After any key event, if no unmasked key is down and mode bit 0 is 0, a pending interrupt clears and `irq_no` returns high one cycle later. With mode bit 0 set, releases never clear it.
- R4: A read of address 0 while mode bit 1 is 1 clears a pending interrupt. With mode bit 1 at 0, the read has no effect on the interrupt.
- R5: A write to address 1 stores wdata bit 14 as the scan flag and bits 13:11 as debounce. When bit 14 is written as 1, a pending interrupt clears.
- R6: A read of address 1 returns the pending flag at bit 15, (scan flag OR no key down) at bit 14, debounce at bits 13:11, and zeros below.
- R7: The mode is written from bits 15:14 at address 2 and reads back there with zeros below. The 16-bit mask is written and read at address 3. Mask and mode writes take effect on the next cycle and do not by themselves change the interrupt.
- R8: After reset the scan flag is 1, debounce is 0, the mask is 0, the mode is 3, the down vector is 0, no interrupt is pending and `irq_no` is high.
- R9: Within one cycle, a clear from a bus access is applied first. Key events are then applied in ascending key index, and the set and clear rules are evaluated after each one, so a press in the same cycle as a clearing access leaves the interrupt pending.
- R10: Reads of any address above 3 return 0xFFFF, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_valid_i | input | 16 | Per-key event strobe |
| key_press_i | input | 16 | Per-key event kind: 1 press, 0 release |
| bus_req_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from current state |
| irq_no | output | 1 | Keypad interrupt, active low |

## Verification
The bench targets press events on masked keys while an unmasked key is still held. A design that only checks the key being pressed would miss that interrupt. It also goes after reads and scan writes in the same cycle as new presses. A design that applied the bus clear after the events would drop an interrupt for a key the host never saw. Mode changes on both bits are exercised: a design that mixes up the two mode bits clears on the wrong trigger. The status bit 14 is checked with keys held and released, and the scan flag both set and clear.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int REG_W = 16;
  typedef logic [REG_W-1:0] reg_t;

  localparam int ADDR_KEYS = 0;
  localparam int ADDR_CTRL = 1;
  localparam int ADDR_MODE = 2;
  localparam int ADDR_MASK = 3;

  localparam int INTR_BIT = 15;
  localparam int SCAN_BIT = 14;
  localparam int DEB_LSB  = 11;
  localparam int DEB_W    = 3;
  localparam int MODE_LSB = 14;
  localparam int MODE_W   = 2;

  localparam logic [MODE_W-1:0] MODE_RST = 2'b11;
  localparam reg_t              UNMAPPED = 16'hFFFF;
endpackage

// File: rtl/kp_cfg_regs.sv
module kp_cfg_regs
  import kp_pkg::*;
#(
  parameter int NUM_KEYS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_ctrl_i,
  input  logic                wr_mode_i,
  input  logic                wr_mask_i,
  input  reg_t                wdata_i,
  output logic                scan_o,
  output logic [DEB_W-1:0]    deb_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic [NUM_KEYS-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_o <= 1'b1;
      deb_o  <= '0;
      mode_o <= MODE_RST;
      mask_o <= '0;
    end else begin
      if (wr_ctrl_i) begin
        scan_o <= wdata_i[SCAN_BIT];
        deb_o  <= wdata_i[DEB_LSB +: DEB_W];
      end
      if (wr_mode_i) mode_o <= wdata_i[MODE_LSB +: MODE_W];
      if (wr_mask_i) mask_o <= wdata_i[NUM_KEYS-1:0];
    end
  end
endmodule

// File: rtl/kp_event_chain.sv
module kp_event_chain #(
  parameter int NUM_KEYS = 16
) (
  input  logic [NUM_KEYS-1:0] down_i,
  input  logic                intr_i,
  input  logic [NUM_KEYS-1:0] mask_i,
  input  logic                hold_i,
  input  logic [NUM_KEYS-1:0] valid_i,
  input  logic [NUM_KEYS-1:0] press_i,
  output logic [NUM_KEYS-1:0] down_o,
  output logic                intr_o
);
  logic [NUM_KEYS-1:0] down_s [NUM_KEYS+1];
  logic                intr_s [NUM_KEYS+1];

  assign down_s[0] = down_i;
  assign intr_s[0] = intr_i;

  // one stage per key, lowest index first
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_stage
    logic [NUM_KEYS-1:0] nxt;
    logic                any_um;
    always_comb begin
      nxt = down_s[k];
      if (valid_i[k]) nxt[k] = press_i[k];
      any_um = |(nxt & ~mask_i);
    end
    always_comb begin
      intr_s[k+1] = intr_s[k];
      if (valid_i[k]) begin
        if (press_i[k] && any_um && !intr_s[k]) intr_s[k+1] = 1'b1;
        else if (intr_s[k] && !any_um && !hold_i) intr_s[k+1] = 1'b0;
      end
    end
    assign down_s[k+1] = nxt;
  end

  assign down_o = down_s[NUM_KEYS];
  assign intr_o = intr_s[NUM_KEYS];
endmodule

// File: rtl/kp_irq_ctrl.sv
module kp_irq_ctrl
  import kp_pkg::*;
#(
  parameter int NUM_KEYS = 16,
  parameter int ADDR_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] key_valid_i,
  input  logic [NUM_KEYS-1:0] key_press_i,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  output logic                irq_no
);
  localparam int PAD_W = REG_W - NUM_KEYS;

  logic [NUM_KEYS-1:0] down_q, down_d, mask_q;
  logic                intr_q, intr_d, intr_mid;
  logic                scan_q;
  logic [DEB_W-1:0]    deb_q;
  logic [MODE_W-1:0]   mode_q;

  logic sel_keys, sel_ctrl, sel_mode, sel_mask;
  logic rd_keys, wr_ctrl, bus_clr;

  assign sel_keys = bus_addr_i == ADDR_W'(ADDR_KEYS);
  assign sel_ctrl = bus_addr_i == ADDR_W'(ADDR_CTRL);
  assign sel_mode = bus_addr_i == ADDR_W'(ADDR_MODE);
  assign sel_mask = bus_addr_i == ADDR_W'(ADDR_MASK);

  assign rd_keys = bus_req_i && !bus_we_i && sel_keys;
  assign wr_ctrl = bus_req_i && bus_we_i && sel_ctrl;

  kp_cfg_regs #(.NUM_KEYS(NUM_KEYS)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (wr_ctrl),
    .wr_mode_i (bus_req_i && bus_we_i && sel_mode),
    .wr_mask_i (bus_req_i && bus_we_i && sel_mask),
    .wdata_i   (bus_wdata_i),
    .scan_o    (scan_q),
    .deb_o     (deb_q),
    .mode_o    (mode_q),
    .mask_o    (mask_q)
  );

  // bus-side clears act before this cycle's key events
  assign bus_clr  = (rd_keys && mode_q[1]) || (wr_ctrl && bus_wdata_i[SCAN_BIT]);
  assign intr_mid = intr_q && !bus_clr;

  kp_event_chain #(.NUM_KEYS(NUM_KEYS)) u_chain (
    .down_i  (down_q),
    .intr_i  (intr_mid),
    .mask_i  (mask_q),
    .hold_i  (mode_q[0]),
    .valid_i (key_valid_i),
    .press_i (key_press_i),
    .down_o  (down_d),
    .intr_o  (intr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      down_q <= '0;
      intr_q <= 1'b0;
    end else begin
      down_q <= down_d;
      intr_q <= intr_d;
    end
  end

  assign irq_no = !intr_q;

  reg_t keys_word, mask_word;
  if (PAD_W > 0) begin : g_pad
    assign keys_word = {{PAD_W{1'b0}}, down_q};
    assign mask_word = {{PAD_W{1'b0}}, mask_q};
  end else begin : g_nopad
    assign keys_word = down_q;
    assign mask_word = mask_q;
  end

  always_comb begin
    bus_rdata_o = UNMAPPED;
    if (sel_keys) bus_rdata_o = keys_word;
    else if (sel_ctrl) begin
      bus_rdata_o = '0;
      bus_rdata_o[INTR_BIT] = intr_q;
      bus_rdata_o[SCAN_BIT] = scan_q || (down_q == '0);
      bus_rdata_o[DEB_LSB +: DEB_W] = deb_q;
    end else if (sel_mode) begin
      bus_rdata_o = '0;
      bus_rdata_o[MODE_LSB +: MODE_W] = mode_q;
    end else if (sel_mask) bus_rdata_o = mask_word;
  end
endmodule

// File: rtl/kp_irq_ctrl_chk.sv
module kp_irq_ctrl_chk
  import kp_pkg::*;
#(
  parameter int NUM_KEYS = 16,
  parameter int ADDR_W   = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_KEYS-1:0] key_valid_i,
  input logic [NUM_KEYS-1:0] key_press_i,
  input logic                bus_req_i,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [REG_W-1:0]    bus_wdata_i,
  input logic                irq_no,
  input logic [NUM_KEYS-1:0] down_q,
  input logic [NUM_KEYS-1:0] mask_q,
  input logic [MODE_W-1:0]   mode_q
);
  logic no_evt, rd_keys, wr_scan1;
  assign no_evt   = key_valid_i == '0;
  assign rd_keys  = bus_req_i && !bus_we_i && bus_addr_i == ADDR_W'(ADDR_KEYS);
  assign wr_scan1 = bus_req_i && bus_we_i && bus_addr_i == ADDR_W'(ADDR_CTRL)
                    && bus_wdata_i[SCAN_BIT];

  a_r1_down_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_evt |=> $stable(down_q));

  a_r1_key0_press: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i[0] && key_press_i[0]) |=> down_q[0]);

  a_r2_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_no && ((key_valid_i & key_press_i & ~mask_q) != '0)) |=> !irq_no);

  a_r3_autoclear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!no_evt && !mode_q[0]) |=> (irq_no || ((down_q & ~$past(mask_q)) != '0)));

  a_r4_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_keys && mode_q[1] && no_evt) |=> irq_no);

  a_r5_scan_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_scan1 && no_evt) |=> irq_no);

  a_r7_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_evt && !(rd_keys && mode_q[1]) && !wr_scan1) |=> $stable(irq_no));
endmodule

bind kp_irq_ctrl kp_irq_ctrl_chk #(.NUM_KEYS(NUM_KEYS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .key_valid_i (key_valid_i),
  .key_press_i (key_press_i),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_no      (irq_no),
  .down_q      (down_q),
  .mask_q      (mask_q),
  .mode_q      (mode_q)
);

// File: tb/kp_irq_ctrl_tb.sv
module kp_irq_ctrl_tb;
  localparam int NK = 16;
  localparam int AW = 4;
  localparam int RAND_CYCLES = 3000;
  localparam int WD_CYCLES = 20000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NK-1:0] key_valid_i = '0;
  logic [NK-1:0] key_press_i = '0;
  logic          bus_req_i = 1'b0;
  logic          bus_we_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [15:0]   bus_wdata_i = '0;
  logic [15:0]   bus_rdata_o;
  logic          irq_no;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  kp_irq_ctrl #(.NUM_KEYS(NK), .ADDR_W(AW)) u_dut (.*);

  // reference state
  logic [15:0] m_down, m_mask;
  logic        m_intr, m_scan;
  logic [2:0]  m_deb;
  logic [1:0]  m_mode;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [AW-1:0] a);
    case (a)
      0: return m_down;
      1: return {m_intr, m_scan || (m_down == 16'h0), m_deb, 11'h0};
      2: return {m_mode, 14'h0};
      3: return m_mask;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic string rd_tag(input logic [AW-1:0] a);
    case (a)
      0: return "R1 key data";
      1: return "R6 status";
      2: return "R7 mode";
      3: return "R7 mask";
      default: return "R10 unmapped";
    endcase
  endfunction

  task automatic model_step(input logic [NK-1:0] v, input logic [NK-1:0] p,
                            input logic rq, input logic we,
                            input logic [AW-1:0] a, input logic [15:0] wd);
    logic um;
    if (rq && !we && a == 0 && m_mode[1]) m_intr = 1'b0;      // R4
    if (rq && we && a == 1 && wd[14]) m_intr = 1'b0;           // R5
    for (int k = 0; k < NK; k++) begin                          // R9
      if (v[k]) begin
        m_down[k] = p[k];
        um = |(m_down & ~m_mask);
        if (p[k] && um && !m_intr) m_intr = 1'b1;
        else if (m_intr && !um && !m_mode[0]) m_intr = 1'b0;
      end
    end
    if (rq && we) begin
      case (a)
        1: begin m_scan = wd[14]; m_deb = wd[13:11]; end
        2: m_mode = wd[15:14];
        3: m_mask = wd;
        default: ;
      endcase
    end
  endtask

  task automatic cycle(input logic [NK-1:0] v, input logic [NK-1:0] p,
                       input logic rq, input logic we,
                       input logic [AW-1:0] a, input logic [15:0] wd,
                       input string tag);
    @(negedge clk_i);
    key_valid_i = v; key_press_i = p;
    bus_req_i = rq; bus_we_i = we; bus_addr_i = a; bus_wdata_i = wd;
    #1;
    if (rq && !we) check(tag == "" ? rd_tag(a) : tag, bus_rdata_o, exp_rd(a));
    model_step(v, p, rq, we, a, wd);
    @(posedge clk_i);
    #1;
    check(tag == "" ? "R2 R3 R4 R5 R9 irq" : tag, {15'h0, irq_no}, {15'h0, !m_intr});
  endtask

  task automatic press(input int k, input string tag);
    cycle(16'(1) << k, 16'(1) << k, 0, 0, 0, 0, tag);
  endtask
  task automatic release_key(input int k, input string tag);
    cycle(16'(1) << k, 16'h0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] wd, input string tag);
    cycle('0, '0, 1, 1, a, wd, tag);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    cycle('0, '0, 1, 0, a, 0, tag);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_down = '0; m_mask = '0; m_intr = 0; m_scan = 1; m_deb = '0; m_mode = 2'b11;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R8 irq after reset", {15'h0, irq_no}, 16'h1);
    rd(1, "R8 status reset");
    rd(2, "R8 mode reset");
    rd(3, "R8 mask reset");
    rd(0, "R8 keys reset");

    // mode 3: no auto clear, read clears
    press(3, "R2 press sets");
    release_key(3, "R3 hold in mode bit0");
    rd(0, "R4 read clears");

    // mode 0: auto clear, read does not clear
    wr(2, 16'h0000, "R7 mode write");
    press(5, "R2 press sets mode0");
    rd(0, "R4 no read clear mode0");
    release_key(5, "R3 auto clear");

    // masking
    wr(3, 16'h0020, "R7 mask write no irq change");
    press(5, "R2 masked press no set");
    press(2, "R2 unmasked press sets");
    wr(1, 16'h2800, "R5 scan0 no clear");
    rd(1, "R6 status keys held");
    wr(1, 16'h4000, "R5 scan write clears");
    wr(1, 16'h2800, "R5 debounce store");
    release_key(2, "R3 release");
    release_key(5, "R3 release masked");
    rd(1, "R6 status no keys");

    // masked press while unmasked key already held, no pending
    wr(2, 16'h8000, "R7 mode 2");
    press(1, "R2 set");
    rd(0, "R4 read clears mode2");
    press(9, "R2 unmasked held");
    rd(0, "R4 clear again");
    press(5, "R2 masked press with unmasked held");

    // same-cycle read clear then press
    cycle(16'h0010, 16'h0010, 1, 0, 0, 0, "R9 clear then press");
    cycle('0, '0, 1, 0, 0, 0, "R9 key data");
    cycle(16'h0100, 16'h0100, 1, 1, 1, 16'h4000, "R9 scan clear then press");

    // unmapped and key-data writes
    rd(7, "R10 unmapped read");
    wr(7, 16'h0000, "R10 unmapped write");
    wr(0, 16'h0000, "R1 key data write ignored");
    rd(0, "R1 key data unchanged");
    rd(2, "R10 mode unchanged");
    rd(3, "R10 mask unchanged");

    void'($urandom(32'd7011));
    for (int i = 0; i < RAND_CYCLES; i++) begin
      logic [NK-1:0] v, p;
      logic rq, we;
      logic [AW-1:0] a;
      int sel;
      v = 16'($urandom & $urandom & $urandom);
      p = 16'($urandom);
      rq = ($urandom_range(0, 1) == 1);
      we = ($urandom_range(0, 1) == 1);
      sel = $urandom_range(0, 4);
      a = (sel == 4) ? AW'(7) : AW'(sel);
      cycle(v, p, rq, we, a, 16'($urandom & $urandom), "");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule